// File: doc/BRIEF.md
# Two-Phase Bridge Burst Generator

This block drives two bridge legs per motor phase from a single fast clock. It outputs a burst of square-wave periods whose length is counted. Each phase leg has a high-side and a low-side control signal. When a pulse count is loaded, the block runs that many drive periods and then returns to idle with every output low. The period, high time, phase offset, dead time and direction are programmable. A host register interface supplies these values as plain input buses, and a single strobe marks each write of the pulse count.

Timing is defined by a tick counter that runs from 0 to T-1 within each period. The leading phase uses the tick directly as its position. The lagging phase uses the tick delayed by the phase offset S, taken modulo T. On each leg, the high-side signal is on for positions D to W-1. The low-side signal is on for positions W+D to T-1. This leaves a gap of D ticks with both signals low after every edge. The block samples the shaping values at the start of every period, so any change takes effect on a period boundary.

Top module: `twoPhaseBurstGen`

## Requirements
- R1: Each drive period lasts T clock cycles. T equals `periodCount` plus the period offset described in R9.
- R2: After a load of a non-zero count N while idle, `busy` is high for exactly N*T consecutive cycles. N may be any value up to 2047.
- R3: A load with a non-zero count while idle raises `busy` on the next cycle, with the tick at 0.
- R4: A load with a count of zero drops `busy` and all four outputs on the next cycle, even in the middle of a burst. All outputs are low whenever `busy` is low.
- R5: With `dirRev`=0, phase 1 leads and phase 2 lags by S ticks. With `dirRev`=1, phase 2 leads and phase 1 lags by S ticks.
- R6: If `widthCode` is 0, the high time W is floor(T/2). Any other value of `widthCode` sets W in ticks.
- R7: If `shiftCode` is 0, the phase offset S is floor(T/4). Any other value of `shiftCode` sets S in ticks.
- R8: The dead time D is 2 ticks when `deadExt`=0. When `deadExt`=1, `deadSel` values 0, 1, 2 and 3 give D of 2, 4, 6 and 8 ticks. On a leg, the high-side and low-side signals are never high together.
- R9: When `calMode` is 0, `periodOffset` (0 to 7) is added to `periodCount`. For any other value of `calMode`, the offset is ignored.
- R10: Bit 0 of `phaseEn` enables the phase 1 outputs and bit 1 enables the phase 2 outputs. A disabled phase holds both of its signals low.
- R11: A non-zero load during a burst replaces the remaining count, and the current period counts as one of the new count. The tick is not restarted.
- R12: While `powerDown` is high, the burst is cleared, `busy` goes low on the next cycle, and loads have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock (one tick) |
| rstN | input | 1 | Active-low synchronous reset |
| periodCount | input | 9 | Period length in ticks |
| periodOffset | input | 3 | Extra ticks added to the period |
| calMode | input | 2 | Calibration mode; non-zero disables the offset |
| pulseCount | input | 11 | Burst length in periods |
| loadCount | input | 1 | Strobe that writes the pulse count |
| dirRev | input | 1 | 1 makes phase 2 lead |
| widthCode | input | 8 | High time in ticks; 0 means half period |
| shiftCode | input | 8 | Phase offset in ticks; 0 means quarter period |
| deadExt | input | 1 | Enables the selectable dead time |
| deadSel | input | 2 | Dead time select (2/4/6/8 ticks) |
| phaseEn | input | 2 | Per-phase output enable |
| powerDown | input | 1 | Forces the block idle |
| ph1Hi | output | 1 | Phase 1 high-side control |
| ph1Lo | output | 1 | Phase 1 low-side control |
| ph2Hi | output | 1 | Phase 2 high-side control |
| ph2Lo | output | 1 | Phase 2 low-side control |
| busy | output | 1 | Burst in progress |

## Verification
Some rules hold on every cycle, and the assertions check these. No leg may turn on both of its signals at once. Every output must be silent while idle. A disabled phase must stay low. The next-cycle response to a start load, a zero load and power-down must be correct. Other properties only show up across a whole scenario, so the bench scenarios cover them. These include the exact burst length, the number of cycles each high-side and low-side signal is on, which phase leads, and whether the period offset applies. They also include a count replaced mid-burst finishing one period after the current one.

// File: rtl/burstGenPkg.sv
package burstGenPkg;
  // Strobes from the burst control to the timing datapath
  typedef struct packed {
    logic kill;   // clear the tick (stop or power-down)
    logic latch;  // start a period: tick to 0, sample shaping values
    logic adv;    // advance the tick within a period
  } dpStrobe_t;
endpackage

// File: rtl/bridgeLeg.sv
module bridgeLeg #(
  parameter int TW = 10,
  parameter int DW = 4
) (
  input  logic [TW-1:0] pos,
  input  logic [TW-1:0] highTime,
  input  logic [TW-1:0] period,
  input  logic [DW-1:0] dead,
  input  logic          enable,
  output logic          hi,
  output logic          lo
);
  logic [TW:0] loStart;

  always_comb begin
    loStart = {1'b0, highTime} + (TW+1)'(dead);
    hi = enable && (pos >= TW'(dead)) && (pos < highTime);
    lo = enable && ({1'b0, pos} >= loStart) && (pos < period);
  end
endmodule

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstGenPkg::*;
#(
  parameter int CNTW = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadCount,
  input  logic [CNTW-1:0] pulseCount,
  input  logic            powerDown,
  input  logic            lastTick,
  output dpStrobe_t       strobe,
  output logic            busy
);
  logic [CNTW-1:0] remain;
  logic killC, zeroLoad;

  assign busy = remain != '0;

  always_comb begin
    zeroLoad     = loadCount && (pulseCount == '0);
    killC        = powerDown || zeroLoad;
    strobe.kill  = killC;
    strobe.latch = !killC && ((loadCount && !busy) || (busy && lastTick));
    strobe.adv   = !killC && busy && !lastTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                remain <= '0;
    else if (powerDown)       remain <= '0;
    else if (loadCount)       remain <= pulseCount;
    else if (busy && lastTick) remain <= remain - CNTW'(1);
  end
endmodule

// File: rtl/burstDatapath.sv
module burstDatapath
  import burstGenPkg::*;
#(
  parameter int PERW  = 9,
  parameter int CODEW = 8,
  parameter int OFSW  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PERW-1:0]  periodCount,
  input  logic [OFSW-1:0]  periodOffset,
  input  logic [1:0]       calMode,
  input  logic [CODEW-1:0] widthCode,
  input  logic [CODEW-1:0] shiftCode,
  input  logic             deadExt,
  input  logic [1:0]       deadSel,
  input  logic             dirRev,
  input  logic             busy,
  input  logic [1:0]       phaseEn,
  output logic             lastTick,
  output logic [1:0]       phaseHi,
  output logic [1:0]       phaseLo
);
  localparam int TW = PERW + 1;
  localparam int DW = 4;

  logic [TW-1:0] tEff, wEff, sEff;
  logic [DW-1:0] dEff;
  logic [2:0]    selPlus;

  logic [TW-1:0] tick, tLat, wLat, sLat, lagPos;
  logic [DW-1:0] dLat;
  logic          dirLat;

  always_comb begin
    tEff    = TW'(periodCount) + ((calMode == 2'd0) ? TW'(periodOffset) : '0);
    wEff    = (widthCode == '0) ? (tEff >> 1) : TW'(widthCode);
    sEff    = (shiftCode == '0) ? (tEff >> 2) : TW'(shiftCode);
    selPlus = {1'b0, deadSel} + 3'd1;
    dEff    = deadExt ? {selPlus, 1'b0} : DW'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick   <= '0;
      tLat   <= TW'(125);
      wLat   <= TW'(62);
      sLat   <= TW'(31);
      dLat   <= DW'(2);
      dirLat <= 1'b0;
    end else if (strobe.kill) begin
      tick <= '0;
    end else if (strobe.latch) begin
      tick   <= '0;
      tLat   <= tEff;
      wLat   <= wEff;
      sLat   <= sEff;
      dLat   <= dEff;
      dirLat <= dirRev;
    end else if (strobe.adv) begin
      tick <= tick + TW'(1);
    end
  end

  always_comb begin
    lastTick = (tick == tLat - TW'(1));
    lagPos   = (tick >= sLat) ? (tick - sLat) : (tick + (tLat - sLat));
  end

  for (genvar i = 0; i < 2; i++) begin : gLeg
    logic [TW-1:0] legPos;
    // phase 1 lags when reversed, phase 2 lags when forward
    assign legPos = (((i == 1) ? 1'b1 : 1'b0) != dirLat) ? lagPos : tick;
    bridgeLeg #(.TW(TW), .DW(DW)) uLeg (
      .pos      (legPos),
      .highTime (wLat),
      .period   (tLat),
      .dead     (dLat),
      .enable   (busy && phaseEn[i]),
      .hi       (phaseHi[i]),
      .lo       (phaseLo[i])
    );
  end
endmodule

// File: rtl/twoPhaseBurstGen.sv
module twoPhaseBurstGen
  import burstGenPkg::*;
#(
  parameter int PERW  = 9,
  parameter int CNTW  = 11,
  parameter int CODEW = 8,
  parameter int OFSW  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PERW-1:0]  periodCount,
  input  logic [OFSW-1:0]  periodOffset,
  input  logic [1:0]       calMode,
  input  logic [CNTW-1:0]  pulseCount,
  input  logic             loadCount,
  input  logic             dirRev,
  input  logic [CODEW-1:0] widthCode,
  input  logic [CODEW-1:0] shiftCode,
  input  logic             deadExt,
  input  logic [1:0]       deadSel,
  input  logic [1:0]       phaseEn,
  input  logic             powerDown,
  output logic             ph1Hi,
  output logic             ph1Lo,
  output logic             ph2Hi,
  output logic             ph2Lo,
  output logic             busy
);
  dpStrobe_t  strobe;
  logic       lastTick;
  logic [1:0] phaseHi, phaseLo;

  burstCtrl #(.CNTW(CNTW)) uCtrl (
    .clk, .rstN, .loadCount, .pulseCount, .powerDown,
    .lastTick, .strobe, .busy
  );

  burstDatapath #(.PERW(PERW), .CODEW(CODEW), .OFSW(OFSW)) uPath (
    .clk, .rstN, .strobe, .periodCount, .periodOffset, .calMode,
    .widthCode, .shiftCode, .deadExt, .deadSel, .dirRev, .busy,
    .phaseEn, .lastTick, .phaseHi, .phaseLo
  );

  assign ph1Hi = phaseHi[0];
  assign ph1Lo = phaseLo[0];
  assign ph2Hi = phaseHi[1];
  assign ph2Lo = phaseLo[1];
endmodule

// File: rtl/burstGenChecker.sv
module burstGenChecker #(
  parameter int CNTW = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            loadCount,
  input logic [CNTW-1:0] pulseCount,
  input logic            powerDown,
  input logic [1:0]      phaseEn,
  input logic            ph1Hi,
  input logic            ph1Lo,
  input logic            ph2Hi,
  input logic            ph2Lo,
  input logic            busy
);
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(ph1Hi && ph1Lo) && !(ph2Hi && ph2Lo));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(ph1Hi || ph1Lo || ph2Hi || ph2Lo));

  a_r10_phase_off: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseEn[0] |-> !(ph1Hi || ph1Lo)) and (!phaseEn[1] |-> !(ph2Hi || ph2Lo)));

  a_r3_start: assert property (@(posedge clk) disable iff (!rstN)
    (loadCount && pulseCount != '0 && !powerDown) |=> busy);

  a_r4_zero_stop: assert property (@(posedge clk) disable iff (!rstN)
    (loadCount && pulseCount == '0) |=> !busy);

  a_r12_power_down: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !busy);
endmodule

bind twoPhaseBurstGen burstGenChecker #(.CNTW(CNTW)) uChk (
  .clk(clk), .rstN(rstN), .loadCount(loadCount), .pulseCount(pulseCount),
  .powerDown(powerDown), .phaseEn(phaseEn), .ph1Hi(ph1Hi), .ph1Lo(ph1Lo),
  .ph2Hi(ph2Hi), .ph2Lo(ph2Lo), .busy(busy)
);

// File: tb/tb_twoPhaseBurstGen.sv
`timescale 1ns/1ps
module tb_twoPhaseBurstGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [8:0]  per = 9'd125;
  logic [2:0]  ofs = 3'd0;
  logic [1:0]  cal = 2'd0;
  logic [10:0] pc = 11'd0;
  logic        load = 1'b0;
  logic        dirRev = 1'b0;
  logic [7:0]  wCode = 8'd0;
  logic [7:0]  sCode = 8'd0;
  logic        dExt = 1'b0;
  logic [1:0]  dSel = 2'd0;
  logic [1:0]  en = 2'b11;
  logic        pd = 1'b0;
  logic ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy;

  always #2 clk = ~clk;

  twoPhaseBurstGen dut (
    .clk(clk), .rstN(rstN), .periodCount(per), .periodOffset(ofs), .calMode(cal),
    .pulseCount(pc), .loadCount(load), .dirRev(dirRev), .widthCode(wCode),
    .shiftCode(sCode), .deadExt(dExt), .deadSel(dSel), .phaseEn(en),
    .powerDown(pd), .ph1Hi(ph1Hi), .ph1Lo(ph1Lo), .ph2Hi(ph2Hi), .ph2Lo(ph2Lo),
    .busy(busy)
  );

  int total = 0, fails = 0;
  int waveErrs = 0;
  logic [4:0] firstAct, firstExp;
  int busyCnt = 0, hi1Cnt = 0, lo1Cnt = 0;

  // reference model of the requirements
  int mRem = 0, mTick = 0, mT = 125, mW = 62, mS = 31, mD = 2;
  logic mDir = 1'b0;

  always @(posedge clk) begin
    int tEff;
    bit wasBusy, last, doLatch;
    if (!rstN) begin
      mRem = 0; mTick = 0;
    end else begin
      tEff = int'(per) + ((cal == 2'd0) ? int'(ofs) : 0);
      wasBusy = (mRem != 0);
      last = wasBusy && (mTick == mT - 1);
      if (pd || (load && pc == 11'd0)) begin
        mRem = 0; mTick = 0;
      end else begin
        doLatch = (load && !wasBusy) || last;
        if (load) mRem = int'(pc);
        else if (last) mRem = mRem - 1;
        if (doLatch) begin
          mTick = 0; mT = tEff;
          mW = (wCode == 8'd0) ? tEff / 2 : int'(wCode);
          mS = (sCode == 8'd0) ? tEff / 4 : int'(sCode);
          mD = dExt ? 2 * (int'(dSel) + 1) : 2;
          mDir = dirRev;
        end else if (wasBusy) mTick = mTick + 1;
      end
    end
  end

  function automatic logic [1:0] legExp(int pos, bit on);
    logic h, l;
    h = on && pos >= mD && pos < mW;
    l = on && pos >= mW + mD && pos < mT;
    return {h, l};
  endfunction

  function automatic logic [4:0] expOut();
    int lag, p1, p2;
    if (mRem == 0) return 5'b0;
    lag = (mTick >= mS) ? mTick - mS : mTick + mT - mS;
    p1 = mDir ? lag : mTick;
    p2 = mDir ? mTick : lag;
    return {legExp(p1, en[0]), legExp(p2, en[1]), 1'b1};
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic stepCycle();
    logic [4:0] a, e;
    @(negedge clk);
    a = {ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy};
    e = expOut();
    if (a !== e) begin
      waveErrs++;
      if (waveErrs == 1) begin firstAct = a; firstExp = e; end
    end
    if (busy) busyCnt++;
    if (ph1Hi) hi1Cnt++;
    if (ph1Lo) lo1Cnt++;
  endtask

  task automatic checkWave(string what);
    check(waveErrs == 0, what, int'(firstAct), int'(firstExp));
    waveErrs = 0;
  endtask

  task automatic runBurst(int n, int expCycles, string what);
    busyCnt = 0; hi1Cnt = 0; lo1Cnt = 0;
    load = 1'b1; pc = 11'(n);
    stepCycle();
    load = 1'b0;
    while (busy) stepCycle();
    check(busyCnt == expCycles, what, busyCnt, expCycles);
  endtask

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) stepCycle();
    check({ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy} == 5'b0, "R4 reset outputs low", int'({ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy}), 0);
    rstN = 1'b1;
    stepCycle();
    waveErrs = 0;

    // R1 R2 R3 R6 R7: defaults, forward
    runBurst(3, 375, "R2 R1 burst length default period");
    check(hi1Cnt == 3 * 60, "R6 R8 default high-side time", hi1Cnt, 180);
    checkWave("R5 R6 R7 forward default waveform");

    // R5 reverse
    dirRev = 1'b1;
    runBurst(2, 250, "R2 reverse burst length");
    checkWave("R5 reverse waveform");
    dirRev = 1'b0;

    // R6 R7 explicit codes
    per = 9'd100; wCode = 8'd30; sCode = 8'd17;
    runBurst(1, 100, "R1 explicit period length");
    check(hi1Cnt == 28, "R6 explicit high time", hi1Cnt, 28);
    checkWave("R6 R7 explicit width and shift");
    wCode = 8'd0; sCode = 8'd0;

    // R8 extended dead time
    per = 9'd125; dExt = 1'b1; dSel = 2'd3;
    runBurst(1, 125, "R8 burst with dead time 8");
    check(hi1Cnt == 54, "R8 high-side with 8-tick gap", hi1Cnt, 54);
    check(lo1Cnt == 55, "R8 low-side with 8-tick gap", lo1Cnt, 55);
    checkWave("R8 extended dead time waveform");
    dSel = 2'd1;
    runBurst(1, 125, "R8 burst with dead time 4");
    check(hi1Cnt == 58, "R8 high-side with 4-tick gap", hi1Cnt, 58);
    dExt = 1'b0;
    runBurst(1, 125, "R8 select ignored when disabled");
    check(hi1Cnt == 60, "R8 select ignored high-side", hi1Cnt, 60);

    // R9 period offset
    per = 9'd100; ofs = 3'd5; cal = 2'd0;
    runBurst(3, 315, "R9 offset applied");
    cal = 2'd2;
    runBurst(3, 300, "R9 offset ignored in calibration");
    checkWave("R9 offset waveforms");
    ofs = 3'd0; cal = 2'd0;

    // R10 phase enable
    en = 2'b10;
    runBurst(2, 200, "R10 burst with phase 1 off");
    check(hi1Cnt + lo1Cnt == 0, "R10 phase 1 silent", hi1Cnt + lo1Cnt, 0);
    checkWave("R10 phase disable waveform");
    en = 2'b11;

    // R4 zero write mid-burst
    load = 1'b1; pc = 11'd5; stepCycle(); load = 1'b0;
    repeat (150) stepCycle();
    load = 1'b1; pc = 11'd0; stepCycle(); load = 1'b0;
    check({ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy} == 5'b0, "R4 zero write stops at once",
          int'({ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy}), 0);
    checkWave("R4 stop waveform");

    // R11 replace count mid-burst
    busyCnt = 0;
    load = 1'b1; pc = 11'd5; stepCycle(); load = 1'b0;
    repeat (149) stepCycle();
    load = 1'b1; pc = 11'd2; stepCycle(); load = 1'b0;
    while (busy) stepCycle();
    check(busyCnt == 300, "R11 replaced count keeps period", busyCnt, 300);
    checkWave("R11 replacement waveform");

    // R12 power-down
    load = 1'b1; pc = 11'd4; stepCycle(); load = 1'b0;
    repeat (40) stepCycle();
    pd = 1'b1; stepCycle();
    check(busy == 1'b0, "R12 power-down clears burst", int'(busy), 0);
    load = 1'b1; pc = 11'd3; stepCycle(); load = 1'b0;
    check({ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy} == 5'b0, "R12 load ignored in power-down",
          int'({ph1Hi, ph1Lo, ph2Hi, ph2Lo, busy}), 0);
    pd = 1'b0; stepCycle();
    checkWave("R12 power-down waveform");

    // R2 maximum count
    per = 9'd20;
    runBurst(2047, 2047 * 20, "R2 maximum count length");
    checkWave("R2 maximum count waveform");

    // random mix
    for (int k = 0; k < 12; k++) begin
      int p, n, t;
      p = 40 + int'($urandom_range(0, 160));
      per = 9'(p);
      ofs = 3'($urandom_range(0, 7));
      cal = 2'($urandom_range(0, 3));
      wCode = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(10, p / 2));
      sCode = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, p / 2));
      dExt = 1'($urandom_range(0, 1));
      dSel = 2'($urandom_range(0, 3));
      dirRev = 1'($urandom_range(0, 1));
      en = 2'($urandom_range(0, 3));
      n = int'($urandom_range(1, 3));
      t = p + ((cal == 2'd0) ? int'(ofs) : 0);
      runBurst(n, n * t, "R1 R2 R9 random burst length");
    end
    checkWave("R5 R6 R7 R8 R10 random waveforms");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule